// File: doc/BRIEF.md
# Double-Buffered Four-Channel DAC Register Bank

This block is the host-facing register bank for four 12-bit digital-to-analog converter channels, A, B, C and D, numbered 0 to 3. Each channel has a code register, a polarity bit and a gain bit. Host writes go into staging registers. In buffered mode, a staged value reaches the converter outputs only when the host reads one of two commit addresses. One commit address carries the control bits of all channels. The other carries the codes of all four channels together. In unbuffered mode, every write reaches the outputs on the next clock edge.

A mode word holds a DAC enable bit and the buffered-mode bit. While the enable bit is clear, all four codes are driven as zero, but the registers inside keep accepting writes and commits. The outputs go to an abstract converter as parallel buses.

Top module: `dac_regbank`

## Requirements
- R1: A write to address 0x14 + 2*i (i = 0 for A to 3 for D) stages wdata[11:0] as the code of channel i; bits 15:12 are dropped. No other address touches a channel code.
- R2: A write to address 0x12 stages the control word: the polarity of channel i is taken from bit 7-i (1 = bipolar) and its gain from bit 11-i. The outputs dac_bipolar[i] and dac_gain[i] belong to channel i. All other bits of the word are ignored.
- R3: A read of address 0x12 copies the staged polarity and gain bits of all channels to dac_bipolar and dac_gain on the next clock edge.
- R4: A read of address 0x02 copies all four staged codes to the active codes on the same clock edge.
- R5: A write to address 0x02 loads the mode word: bit 1 is the DAC enable and bit 0 is buffered mode.
- R6: While buffered mode is set, writes to codes or control do not change any output until the matching commit read.
- R7: While buffered mode is clear, a code or control write appears on the outputs on the clock edge that takes the write, with no commit read.
- R8: While the enable bit is clear, every code output reads zero, and code writes and commits still update the registers inside. Setting the enable bit again shows the committed codes.
- R9: Reset clears the mode word, all staged and active codes, and all polarity and gain bits, so every output is zero.
- R10: A read that is asserted in the same cycle as a write commits nothing; the write is performed. A read of any address other than 0x02 or 0x12 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe (commit trigger) |
| bus_addr | input | 6 | Host byte address |
| bus_wdata | input | 16 | Host write data |
| dac_code | output | 48 | Active codes; channel i in bits 12*i+11 to 12*i |
| dac_bipolar | output | 4 | Active polarity per channel, 1 = bipolar |
| dac_gain | output | 4 | Active gain bit per channel |

## Verification
The hardest case to reach is a staged value that differs from the active value while the mode or enable changes. Examples are codes committed while the outputs are forced to zero, or a commit read that arrives in the same cycle as a write to the same control address. The stimulus reaches these cases with directed sequences. It stages new codes in buffered mode and disables the DAC before committing them. Only after that does it enable the DAC again. It also asserts both strobes together on the control address. A behavioural model compares all outputs on every clock, so any early or missing transfer from staging to active shows up.

// File: rtl/dac_regbank_pkg.sv
package dac_regbank_pkg;
  localparam int NCH_DEF = 4;
  localparam int DW_DEF  = 12;
  localparam int AW_DEF  = 6;
  localparam int BW      = 16;

  localparam logic [15:0] ADR_MODE  = 16'h0002;
  localparam logic [15:0] ADR_DCTL  = 16'h0012;
  localparam logic [15:0] ADR_DATA0 = 16'h0014;

  localparam int POL_TOP  = 7;
  localparam int GAIN_TOP = 11;
  localparam int EN_BIT   = 1;
  localparam int BUF_BIT  = 0;

  function automatic logic [15:0] data_addr(input int ch);
    return ADR_DATA0 + 16'(ch * 2);
  endfunction

  function automatic int pol_pos(input int ch);
    return POL_TOP - ch;
  endfunction

  function automatic int gain_pos(input int ch);
    return GAIN_TOP - ch;
  endfunction
endpackage

// File: rtl/dac_addr_decode.sv
module dac_addr_decode
  import dac_regbank_pkg::*;
#(
  parameter int NCH = NCH_DEF,
  parameter int AW  = AW_DEF
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [AW-1:0]  bus_addr,
  output logic           wr_mode,
  output logic           wr_dctl,
  output logic [NCH-1:0] wr_chan,
  output logic           cm_ctrl,
  output logic           cm_data
);
  logic [15:0] addr_x;
  logic        rd_only;

  assign addr_x  = 16'(bus_addr);
  assign rd_only = bus_rd && !bus_wr;
  assign wr_mode = bus_wr && (addr_x == ADR_MODE);
  assign wr_dctl = bus_wr && (addr_x == ADR_DCTL);
  assign cm_ctrl = rd_only && (addr_x == ADR_DCTL);
  assign cm_data = rd_only && (addr_x == ADR_MODE);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chdec
    assign wr_chan[ch] = bus_wr && (addr_x == data_addr(ch));
  end

  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_chan, wr_mode, wr_dctl})); // R1
endmodule

// File: rtl/dac_chan_reg.sv
module dac_chan_reg #(
  parameter int DW = 12,
  parameter int BW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [BW-1:0] wdata,
  input  logic          buffered,
  input  logic          commit,
  output logic [DW-1:0] act
);
  logic [DW-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
      act <= '0;
    end else begin
      if (wr) begin
        stg <= wdata[DW-1:0];
        if (!buffered) act <= wdata[DW-1:0];
      end else if (commit) begin
        act <= stg;
      end
    end
  end

  AST_DATA_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !wr |=> act == $past(stg)); // R4
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    buffered && !commit |=> $stable(act)); // R6
  AST_DATA_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    wr && !buffered |=> act == $past(wdata[DW-1:0])); // R7
endmodule

// File: rtl/dac_ctrl_reg.sv
module dac_ctrl_reg
  import dac_regbank_pkg::*;
#(
  parameter int NCH = NCH_DEF
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_mode,
  input  logic           wr_dctl,
  input  logic           cm_ctrl,
  input  logic [BW-1:0]  wdata,
  output logic           en,
  output logic           buffered,
  output logic [NCH-1:0] pol_act,
  output logic [NCH-1:0] gain_act
);
  logic [NCH-1:0] pol_stg, gain_stg;
  logic [NCH-1:0] pol_in, gain_in;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_field
    assign pol_in[ch]  = wdata[pol_pos(ch)];
    assign gain_in[ch] = wdata[gain_pos(ch)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= 1'b0;
      buffered <= 1'b0;
    end else if (wr_mode) begin
      en       <= wdata[EN_BIT];
      buffered <= wdata[BUF_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_stg  <= '0;
      gain_stg <= '0;
      pol_act  <= '0;
      gain_act <= '0;
    end else begin
      if (wr_dctl) begin
        pol_stg  <= pol_in;
        gain_stg <= gain_in;
        if (!buffered) begin
          pol_act  <= pol_in;
          gain_act <= gain_in;
        end
      end else if (cm_ctrl) begin
        pol_act  <= pol_stg;
        gain_act <= gain_stg;
      end
    end
  end

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |=> en == $past(wdata[EN_BIT]) && buffered == $past(wdata[BUF_BIT])); // R5
  AST_CTRL_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cm_ctrl |=> pol_act == $past(pol_stg) && gain_act == $past(gain_stg)); // R3
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    buffered && !cm_ctrl |=> $stable(pol_act) && $stable(gain_act)); // R6
endmodule

// File: rtl/dac_regbank.sv
module dac_regbank
  import dac_regbank_pkg::*;
#(
  parameter int NCH = NCH_DEF,
  parameter int DW  = DW_DEF,
  parameter int AW  = AW_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [BW-1:0]     bus_wdata,
  output logic [NCH*DW-1:0] dac_code,
  output logic [NCH-1:0]    dac_bipolar,
  output logic [NCH-1:0]    dac_gain
);
  logic           wr_mode, wr_dctl, cm_ctrl, cm_data;
  logic [NCH-1:0] wr_chan;
  logic           en, buffered;
  logic [DW-1:0]  act_code [NCH];

  dac_addr_decode #(.NCH(NCH), .AW(AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .wr_mode(wr_mode), .wr_dctl(wr_dctl),
    .wr_chan(wr_chan), .cm_ctrl(cm_ctrl), .cm_data(cm_data)
  );

  dac_ctrl_reg #(.NCH(NCH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_mode(wr_mode), .wr_dctl(wr_dctl),
    .cm_ctrl(cm_ctrl), .wdata(bus_wdata), .en(en), .buffered(buffered),
    .pol_act(dac_bipolar), .gain_act(dac_gain)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    dac_chan_reg #(.DW(DW), .BW(BW)) u_chan (
      .clk(clk), .rst_n(rst_n), .wr(wr_chan[ch]), .wdata(bus_wdata),
      .buffered(buffered), .commit(cm_data), .act(act_code[ch])
    );
    assign dac_code[ch*DW +: DW] = en ? act_code[ch] : '0;
  end

  AST_NO_COMMIT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_rd |-> !cm_ctrl && !cm_data); // R10
  AST_ZERO_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode && !bus_wdata[EN_BIT] |=> dac_code == '0); // R8
endmodule

// File: tb/dac_regbank_tb.sv
module dac_regbank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [47:0] dac_code;
  logic [3:0]  dac_bipolar, dac_gain;

  int checks = 0, errors = 0;
  bit done = 0;
  string phase = "R9";

  int m_stg[4], m_act[4];
  bit m_pstg[4], m_gstg[4], m_pact[4], m_gact[4];
  bit m_en, m_buf;

  always #10 clk = ~clk;

  dac_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .dac_code(dac_code),
    .dac_bipolar(dac_bipolar), .dac_gain(dac_gain)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_stg[i] = 0; m_act[i] = 0;
        m_pstg[i] = 0; m_gstg[i] = 0; m_pact[i] = 0; m_gact[i] = 0;
      end
      m_en = 0; m_buf = 0;
    end else if (bus_wr) begin
      bit old_buf;
      int a;
      old_buf = m_buf;
      a = int'(bus_addr);
      if (a == 2) begin
        m_en = bus_wdata[1]; m_buf = bus_wdata[0];
      end else if (a == 18) begin
        for (int i = 0; i < 4; i++) begin
          m_pstg[i] = bus_wdata[7-i]; m_gstg[i] = bus_wdata[11-i];
          if (!old_buf) begin m_pact[i] = m_pstg[i]; m_gact[i] = m_gstg[i]; end
        end
      end else if (a >= 20 && a <= 26 && (a % 2) == 0) begin
        int i;
        i = (a - 20) / 2;
        m_stg[i] = int'(bus_wdata) % 4096;
        if (!old_buf) m_act[i] = m_stg[i];
      end
    end else if (bus_rd) begin
      if (int'(bus_addr) == 18)
        for (int i = 0; i < 4; i++) begin m_pact[i] = m_pstg[i]; m_gact[i] = m_gstg[i]; end
      else if (int'(bus_addr) == 2)
        for (int i = 0; i < 4; i++) m_act[i] = m_stg[i];
    end
  end

  always @(posedge clk) begin
    #5;
    for (int i = 0; i < 4; i++) begin
      int exp_code;
      exp_code = m_en ? m_act[i] : 0;
      checks++;
      if (int'(dac_code[i*12 +: 12]) != exp_code || dac_bipolar[i] != m_pact[i]
          || dac_gain[i] != m_gact[i]) begin
        errors++;
        $display("FAIL %s model ch%0d: code=%0h pol=%0b gain=%0b expected code=%0h pol=%0b gain=%0b",
                 phase, i, dac_code[i*12 +: 12], dac_bipolar[i], dac_gain[i],
                 exp_code, m_pact[i], m_gact[i]);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op(input bit w, input bit r, input int a, input int d);
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_addr = 6'(a); bus_wdata = 16'(d);
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
  endtask

  function automatic int code(input int i);
    return int'(dac_code[i*12 +: 12]);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset code", int'(dac_code), 0);
    check("R9 reset ctrl", int'({dac_bipolar, dac_gain}), 0);
    rst_n = 1;

    phase = "R7";
    op(1, 0, 2, 16'h0002);
    op(1, 0, 16'h14, 16'hF123);
    check("R1 R7 ch A direct, top bits dropped", code(0), 12'h123);
    op(1, 0, 16'h16, 16'h0456);
    op(1, 0, 16'h18, 16'h0789);
    op(1, 0, 16'h1A, 16'h0ABC);
    check("R1 ch B", code(1), 12'h456);
    check("R1 ch C", code(2), 12'h789);
    check("R1 ch D", code(3), 12'hABC);
    phase = "R2";
    op(1, 0, 16'h12, 16'hFA5F);
    check("R2 polarity bits 7..4 map A..D", int'(dac_bipolar), 4'b1010);
    check("R2 gain bits 11..8 map A..D", int'(dac_gain), 4'b0101);

    phase = "R6";
    op(1, 0, 2, 16'h0003);
    op(1, 0, 16'h14, 16'h0111);
    op(1, 0, 16'h1A, 16'h0DDD);
    op(1, 0, 16'h12, 16'h0F00);
    check("R6 ch A held", code(0), 12'h123);
    check("R6 ch D held", code(3), 12'hABC);
    check("R6 ctrl held", int'({dac_bipolar, dac_gain}), 8'b1010_0101);
    phase = "R4";
    op(0, 1, 2, 0);
    check("R4 commit ch A", code(0), 12'h111);
    check("R4 commit ch D", code(3), 12'hDDD);
    check("R4 ctrl not committed by data read", int'({dac_bipolar, dac_gain}), 8'b1010_0101);
    phase = "R3";
    op(0, 1, 16'h12, 0);
    check("R3 commit ctrl", int'({dac_bipolar, dac_gain}), 8'b0000_1111);

    phase = "R10";
    op(1, 0, 16'h12, 16'h00F0);
    op(1, 1, 16'h12, 16'h0080);
    check("R10 combined rd+wr no commit", int'({dac_bipolar, dac_gain}), 8'b0000_1111);
    op(1, 0, 16'h16, 16'h0222);
    op(0, 1, 16'h16, 0);
    op(0, 1, 16'h00, 0);
    check("R10 read of other address no commit", code(1), 12'h456);
    op(0, 1, 16'h12, 0);
    check("R10 staged value from combined write", int'(dac_bipolar), 4'b0001);

    phase = "R8";
    op(1, 0, 2, 16'h0001);
    check("R8 disabled codes zero", int'(dac_code), 0);
    op(1, 0, 16'h18, 16'h0333);
    op(0, 1, 2, 0);
    check("R8 still zero after commit", int'(dac_code), 0);
    op(1, 0, 2, 16'h0003);
    check("R8 re-enable shows committed C", code(2), 12'h333);
    check("R8 re-enable shows committed B", code(1), 12'h222);
    op(1, 0, 2, 16'h0000);
    op(1, 0, 16'h14, 16'h0555);
    op(1, 0, 2, 16'h0002);
    check("R7 R8 unbuffered write while disabled kept", code(0), 12'h555);

    phase = "R9";
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    check("R9 reset mid-run", int'({dac_code, dac_bipolar, dac_gain}), 0);
    rst_n = 1;
    op(1, 0, 2, 16'h0002);
    check("R9 staged cleared by reset", code(3), 0);
    repeat (2) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog %s: actual=hung expected=done", phase);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule